// File: doc/BRIEF.md
# Watchdog timer with pretimeout

This peripheral holds two 32-bit down-counters: a main watchdog counter and a pretimeout counter that software loads with a smaller value, so that it runs out first and warns that the watchdog is about to bite. Each counter advances on one of two tick sources: a shared free-running prescaler that divides the core clock by a power of two, or an externally supplied reference tick strobe. Software reaches the control, status and both count registers over a simple single-cycle register bus. Writing a count register reloads the counter at once. This is the keepalive. Reading a count register returns the live remaining count.

When a counter runs down to zero it latches a sticky expiry flag, pulses its interrupt output for one clock, and stays at zero until it is reloaded. A small reset-out block has its own select line and holds an enable register and a mask register. A watchdog expiry starts a fixed-length reset pulse. That pulse reaches the output only while three conditions hold together: reset-out is enabled, reset-out is not masked, and the watchdog counter is enabled.

Top module: `wdt_pretimeout_top`

## Requirements
- R1: The control register sits at offset 0x00 on the timer select. Bit 2 enables the pretimeout counter and bit 8 enables the watchdog counter. Bit 12 gives the pretimeout counter the reference tick and bit 10 gives the watchdog counter the reference tick. Bits 18:16 hold the prescaler exponent. All other bits read as zero, and every control bit resets to zero.
- R2: When a counter's reference-tick select bit is clear, the counter steps once every 2^P clocks, where P is the prescaler exponent. Both counters share one prescaler phase, so their expiries are exactly (Nw−Np)·2^P clocks apart. When the select bit is set, the counter steps only on cycles where ref_tick is high.
- R3: An enabled counter decrements by one per tick. Clearing its enable bit freezes the count. Setting the enable bit again resumes counting from the frozen value, with no reload.
- R4: Both counters reset to 0xFFFFFFFF. A write to offset 0x1C loads the pretimeout counter and a write to offset 0x34 loads the watchdog counter; the load takes effect at once and wins over a tick in the same cycle. Reads of those offsets return the live count.
- R5: When a counter reaches zero, its interrupt output is high for exactly one clock and the counter then holds at zero. Its status flag is set in the same clock: bit 31 of the status register (offset 0x04) for the watchdog, bit 8 for the pretimeout counter.
- R6: Writing 0 to a status flag bit clears that flag. Writing 1 to a status flag bit leaves it unchanged.
- R7: With the pretimeout counter loaded below the watchdog counter and both enabled together, the pretimeout interrupt comes strictly before the watchdog interrupt.
- R8: The reset-out block is selected by bus_sel_rst. The enable register is at offset 0x00 (bit 8) and the mask register is at offset 0x04 (bit 10); both reset to zero. A watchdog expiry with enable set, mask clear and the watchdog enabled drives rst_out high for exactly 16 clocks, starting in the clock that watchdog_irq is high.
- R9: rst_out stays low after a watchdog expiry if the reset-out enable bit is clear or the mask bit is set. Clearing the watchdog enable bit during a pulse drops rst_out at once.
- R10: Reloading the watchdog counter before it reaches zero prevents any expiry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | Reference tick strobe, one clock wide |
| bus_sel_wdt | input | 1 | Selects the timer register space |
| bus_sel_rst | input | 1 | Selects the reset-out register space |
| bus_wr | input | 1 | Write strobe, 1 = write |
| bus_addr | input | 8 | Byte offset within the selected space |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| pto_irq | output | 1 | One-clock pretimeout expiry pulse |
| wdg_irq | output | 1 | One-clock watchdog expiry pulse |
| rst_out | output | 1 | Gated reset-out pulse |

## Verification
The hardest case to reach from the ports is a watchdog expiry in which exactly one reset-gating condition fails, and in particular the case where the watchdog enable is removed while a reset pulse is already running. The stimulus reaches it by arming the gate, letting a short count expire at the full clock rate, and clearing the watchdog enable a few clocks into the pulse. Randomly drawn reload values and prescaler exponents check the exact spacing between the two expiries. A directed sequence drives the reference tick by hand to confirm that counting stops whenever no reference strobe arrives.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int DIV_W  = 3;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_STAT = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_PTO  = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_WDG  = 8'h34;

    localparam int B_PTO_EN  = 2;
    localparam int B_WDG_EN  = 8;
    localparam int B_WDG_FIX = 10;
    localparam int B_PTO_FIX = 12;
    localparam int B_DIV_LO  = 16;
    localparam int B_WDG_EXP = 31;
    localparam int B_PTO_EXP = 8;
    localparam int B_RO_EN   = 8;
    localparam int B_RO_MASK = 10;

    typedef struct packed {
        logic             pto_en;
        logic             wdg_en;
        logic             wdg_fix;
        logic             pto_fix;
        logic [DIV_W-1:0] div;
    } ctrl_t;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_sel,
    output logic             tick_o
);
    localparam int CNT_W = (1 << DIV_W) - 1;

    logic [CNT_W-1:0] cnt_d, cnt_q, mask;

    always_comb begin
        cnt_d  = cnt_q + 1'b1;
        mask   = (CNT_W'(1) << div_sel) - CNT_W'(1);
        tick_o = &(cnt_q | ~mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R2: with a divider above one, two ticks never fall on adjacent clocks
    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && div_sel != '0) |=> (!tick_o || !$stable(div_sel)));
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_i,
    input  logic         tick_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic [W-1:0] count_o,
    output logic         expire_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d    = cnt_q;
        expire_o = 1'b0;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (run_i && tick_i && cnt_q != '0) begin
            cnt_d    = cnt_q - 1'b1;
            expire_o = (cnt_q == W'(1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '1;
        else        cnt_q <= cnt_d;
    end

    assign count_o = cnt_q;

    // R3: one step down per tick
    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && tick_i && !load_i && count_o != '0) |=> count_o == $past(count_o) - 1'b1);
    // R3: frozen while disabled
    a_r3_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !load_i) |=> $stable(count_o));
    // R5: zero is held until a reload
    a_r5_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o == '0 && !load_i) |=> count_o == '0);
endmodule

// File: rtl/wdt_rstout.sv
module wdt_rstout #(
    parameter int PULSE_LEN = 16,
    parameter int DATA_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              mask_sel_i,
    input  logic              en_bit_i,
    input  logic              mask_bit_i,
    input  logic              wdg_run_i,
    input  logic              wdg_expire_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rst_o
);
    import wdt_pkg::*;
    localparam int CW = $clog2(PULSE_LEN + 1);

    typedef struct packed {
        logic          en;
        logic          mask;
        logic [CW-1:0] cnt;
    } ro_t;

    ro_t s_d, s_q;
    logic gate;

    always_comb begin
        s_d  = s_q;
        gate = s_q.en && !s_q.mask && wdg_run_i;
        if (wr_i && !mask_sel_i) s_d.en   = en_bit_i;
        if (wr_i &&  mask_sel_i) s_d.mask = mask_bit_i;
        if (wdg_expire_i && gate)  s_d.cnt = CW'(PULSE_LEN);
        else if (s_q.cnt != '0)    s_d.cnt = s_q.cnt - 1'b1;
        rdata_o = '0;
        if (mask_sel_i) rdata_o[B_RO_MASK] = s_q.mask;
        else            rdata_o[B_RO_EN]   = s_q.en;
        rst_o = (s_q.cnt != '0) && gate;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R8: a gated expiry produces reset-out in the next clock
    a_r8_pulse_start: assert property (@(posedge clk) disable iff (!rst_n)
        (wdg_expire_i && s_q.en && !s_q.mask && wdg_run_i && !wr_i) |=> rst_o);
    // R9: reset-out never shows while the watchdog is disabled
    a_r9_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        !wdg_run_i |-> !rst_o);
endmodule

// File: rtl/wdt_pretimeout_top.sv
module wdt_pretimeout_top #(
    parameter int PULSE_LEN = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ref_tick,
    input  logic        bus_sel_wdt,
    input  logic        bus_sel_rst,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        pto_irq,
    output logic        wdg_irq,
    output logic        rst_out
);
    import wdt_pkg::*;
    localparam int NCNT = 2;   // index 0: pretimeout, 1: watchdog

    typedef struct packed {
        ctrl_t ctrl;
        logic  wdg_flag;
        logic  pto_flag;
        logic  wdg_irq;
        logic  pto_irq;
    } top_t;

    top_t s_d, s_q;
    logic wdt_wr, div_tick;
    logic [NCNT-1:0] run, tick, load, expire;
    logic [DATA_W-1:0] cnt [NCNT];
    logic [DATA_W-1:0] ro_rdata;
    logic unused_wdata;

    assign wdt_wr = bus_sel_wdt && bus_wr;
    assign unused_wdata = ^{bus_addr[7:3], bus_addr[1:0]};

    wdt_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .div_sel(s_q.ctrl.div), .tick_o(div_tick)
    );

    for (genvar g = 0; g < NCNT; g++) begin : g_cnt
        assign run[g]  = (g == 0) ? s_q.ctrl.pto_en : s_q.ctrl.wdg_en;
        assign tick[g] = ((g == 0) ? s_q.ctrl.pto_fix : s_q.ctrl.wdg_fix) ? ref_tick : div_tick;
        assign load[g] = wdt_wr && (bus_addr == ((g == 0) ? OFS_PTO : OFS_WDG));
        wdt_countdown #(.W(DATA_W)) u_cd (
            .clk(clk), .rst_n(rst_n), .run_i(run[g]), .tick_i(tick[g]),
            .load_i(load[g]), .load_val_i(bus_wdata),
            .count_o(cnt[g]), .expire_o(expire[g])
        );
    end

    wdt_rstout #(.PULSE_LEN(PULSE_LEN), .DATA_W(DATA_W)) u_ro (
        .clk(clk), .rst_n(rst_n),
        .wr_i(bus_sel_rst && bus_wr), .mask_sel_i(bus_addr[2]),
        .en_bit_i(bus_wdata[B_RO_EN]), .mask_bit_i(bus_wdata[B_RO_MASK]),
        .wdg_run_i(s_q.ctrl.wdg_en), .wdg_expire_i(expire[1]),
        .rdata_o(ro_rdata), .rst_o(rst_out)
    );

    always_comb begin
        s_d = s_q;
        s_d.pto_irq = expire[0];
        s_d.wdg_irq = expire[1];
        if (wdt_wr && bus_addr == OFS_CTRL) begin
            s_d.ctrl.pto_en  = bus_wdata[B_PTO_EN];
            s_d.ctrl.wdg_en  = bus_wdata[B_WDG_EN];
            s_d.ctrl.wdg_fix = bus_wdata[B_WDG_FIX];
            s_d.ctrl.pto_fix = bus_wdata[B_PTO_FIX];
            s_d.ctrl.div     = bus_wdata[B_DIV_LO +: DIV_W];
        end
        if (wdt_wr && bus_addr == OFS_STAT) begin
            if (!bus_wdata[B_WDG_EXP]) s_d.wdg_flag = 1'b0;
            if (!bus_wdata[B_PTO_EXP]) s_d.pto_flag = 1'b0;
        end
        if (expire[1]) s_d.wdg_flag = 1'b1;
        if (expire[0]) s_d.pto_flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel_rst) begin
            bus_rdata = ro_rdata;
        end else if (bus_sel_wdt) begin
            case (bus_addr)
                OFS_CTRL: begin
                    bus_rdata[B_PTO_EN]            = s_q.ctrl.pto_en;
                    bus_rdata[B_WDG_EN]            = s_q.ctrl.wdg_en;
                    bus_rdata[B_WDG_FIX]           = s_q.ctrl.wdg_fix;
                    bus_rdata[B_PTO_FIX]           = s_q.ctrl.pto_fix;
                    bus_rdata[B_DIV_LO +: DIV_W]   = s_q.ctrl.div;
                end
                OFS_STAT: begin
                    bus_rdata[B_WDG_EXP] = s_q.wdg_flag;
                    bus_rdata[B_PTO_EXP] = s_q.pto_flag;
                end
                OFS_PTO: bus_rdata = cnt[0];
                OFS_WDG: bus_rdata = cnt[1];
                default: bus_rdata = '0;
            endcase
        end
    end

    assign pto_irq = s_q.pto_irq;
    assign wdg_irq = s_q.wdg_irq;

    // R5: interrupt is a single clock wide
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wdg_irq |=> !wdg_irq);
    // R5: flag only rises together with the interrupt
    a_r5_flag_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.wdg_flag) |-> wdg_irq);
    // R5: the counter is at zero when the interrupt shows
    a_r5_zero_at_irq: assert property (@(posedge clk) disable iff (!rst_n)
        pto_irq |-> cnt[0] == '0);
    // R6: writing one to a set flag keeps it
    a_r6_write_one_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_wr && bus_addr == OFS_STAT && bus_wdata[B_WDG_EXP] && s_q.wdg_flag) |=> s_q.wdg_flag);
endmodule

// File: tb/sim_wdt_pretimeout_top.sv
module sim_wdt_pretimeout_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_tick = 1'b0;
    logic bus_sel_wdt = 1'b0, bus_sel_rst = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic pto_irq, wdg_irq, rst_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;   // 250 MHz

    wdt_pretimeout_top u0 (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
        .bus_sel_wdt(bus_sel_wdt), .bus_sel_rst(bus_sel_rst), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pto_irq(pto_irq), .wdg_irq(wdg_irq), .rst_out(rst_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic rsel, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel_wdt = !rsel; bus_sel_rst = rsel; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel_wdt = 1'b0; bus_sel_rst = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic rsel, input logic [7:0] a, output logic [31:0] d);
        bus_sel_wdt = !rsel; bus_sel_rst = rsel; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel_wdt = 1'b0; bus_sel_rst = 1'b0;
    endtask

    task automatic pulse_ref();
        @(negedge clk); ref_tick = 1'b1;
        @(negedge clk); ref_tick = 1'b0;
    endtask

    // waits for the watchdog interrupt, returns with the clock it shows
    task automatic wait_wdg(input int limit, output int got);
        got = 0;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (wdg_irq) begin got = 1; break; end
        end
    endtask

    task automatic arm_expiry(input logic [31:0] ro_en, input logic [31:0] ro_mask, output int got);
        wr(1'b0, 8'h00, 32'h0);
        wr(1'b0, 8'h04, 32'h0);
        wr(1'b1, 8'h00, ro_en);
        wr(1'b1, 8'h04, ro_mask);
        wr(1'b0, 8'h34, 32'd4);
        wr(1'b0, 8'h00, 32'h0000_0100);
        wait_wdg(100, got);
    endtask

    function automatic logic [31:0] spacing(input int nw, input int np, input int p);
        return 32'((nw - np) << p);
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog expired, run hung");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, c1, c2, c3;
        int got, seed, t1, t2, n, seen;
        seed = $urandom(5150);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        rd(1'b0, 8'h00, v); check("R1 ctrl reset", v, 32'h0);
        rd(1'b0, 8'h04, v); check("R5 status reset", v, 32'h0);
        rd(1'b0, 8'h1C, v); check("R4 pto reset", v, 32'hFFFF_FFFF);
        rd(1'b0, 8'h34, v); check("R4 wdg reset", v, 32'hFFFF_FFFF);
        rd(1'b1, 8'h00, v); check("R8 ro enable reset", v, 32'h0);
        rd(1'b1, 8'h04, v); check("R8 ro mask reset", v, 32'h0);
        check("R8 rst_out reset", {31'b0, rst_out}, 32'h0);

        // R1 control layout
        wr(1'b0, 8'h00, 32'hFFFF_FFFF);
        rd(1'b0, 8'h00, v); check("R1 ctrl readback", v, 32'h0007_1504);
        wr(1'b0, 8'h00, 32'h0);
        wr(1'b1, 8'h00, 32'hFFFF_FFFF);
        rd(1'b1, 8'h00, v); check("R8 ro enable readback", v, 32'h0000_0100);
        wr(1'b1, 8'h04, 32'hFFFF_FFFF);
        rd(1'b1, 8'h04, v); check("R8 ro mask readback", v, 32'h0000_0400);
        wr(1'b1, 8'h00, 32'h0);
        wr(1'b1, 8'h04, 32'h0);

        // R4 reload and live read
        wr(1'b0, 8'h34, 32'd1234);
        rd(1'b0, 8'h34, v); check("R4 wdg load", v, 32'd1234);

        // R2 reference tick path, R5 expiry
        wr(1'b0, 8'h34, 32'd3);
        wr(1'b0, 8'h00, 32'h0000_0500);
        repeat (40) @(negedge clk);
        rd(1'b0, 8'h34, v); check("R2 no ref tick no count", v, 32'd3);
        pulse_ref();
        rd(1'b0, 8'h34, v); check("R2 one ref tick", v, 32'd2);
        pulse_ref();
        pulse_ref();
        check("R5 wdg irq after last tick", {31'b0, wdg_irq}, 32'd1);
        rd(1'b0, 8'h04, v); check("R5 wdg flag set", v, 32'h8000_0000);
        @(negedge clk);
        check("R5 irq one clock", {31'b0, wdg_irq}, 32'd0);
        repeat (5) pulse_ref();
        rd(1'b0, 8'h34, v); check("R5 holds zero", v, 32'd0);

        // R6 status clear
        wr(1'b0, 8'h04, 32'hFFFF_FFFF);
        rd(1'b0, 8'h04, v); check("R6 write one keeps", v, 32'h8000_0000);
        wr(1'b0, 8'h04, 32'h7FFF_FFFF);
        rd(1'b0, 8'h04, v); check("R6 write zero clears", v, 32'h0);

        // R3 freeze and resume
        wr(1'b0, 8'h00, 32'h0);
        wr(1'b0, 8'h34, 32'd1000);
        wr(1'b0, 8'h00, 32'h0000_0100);
        repeat (10) @(negedge clk);
        wr(1'b0, 8'h00, 32'h0);
        rd(1'b0, 8'h34, c1);
        repeat (20) @(negedge clk);
        rd(1'b0, 8'h34, c2); check("R3 frozen", c2, c1);
        wr(1'b0, 8'h00, 32'h0000_0100);
        repeat (5) @(negedge clk);
        rd(1'b0, 8'h34, c3);
        check("R3 resumed without reload", {31'b0, (c3 < c1) && (c3 + 20 > c1)}, 32'd1);

        // R10 keepalive
        wr(1'b0, 8'h00, 32'h0);
        wr(1'b0, 8'h04, 32'h0);
        wr(1'b0, 8'h34, 32'd20);
        wr(1'b0, 8'h00, 32'h0000_0100);
        seen = 0;
        for (int k = 0; k < 12; k++) begin
            for (int j = 0; j < 10; j++) begin
                @(negedge clk);
                if (wdg_irq) seen = 1;
            end
            wr(1'b0, 8'h34, 32'd20);
        end
        check("R10 no expiry while fed", seen, 32'd0);
        wait_wdg(60, got);
        check("R10 expiry once feeding stops", got, 32'd1);

        // R2 R7 random spacing and order
        for (int it = 0; it < 8; it++) begin
            int p, np, nw;
            p  = $urandom_range(0, 3);
            np = $urandom_range(1, 6);
            nw = np + $urandom_range(1, 5);
            wr(1'b0, 8'h00, 32'h0);
            wr(1'b0, 8'h1C, 32'(np));
            wr(1'b0, 8'h34, 32'(nw));
            wr(1'b0, 8'h00, 32'h0000_0104 | (32'(p) << 16));
            t1 = -1; t2 = -1;
            for (int c = 0; c < 400 && t2 < 0; c++) begin
                @(negedge clk);
                if (pto_irq && t1 < 0) t1 = c;
                if (wdg_irq && t2 < 0) t2 = c;
            end
            check("R7 pto before wdg", {31'b0, (t1 >= 0) && (t1 < t2)}, 32'd1);
            check("R2 expiry spacing", 32'(t2 - t1), spacing(nw, np, p));
        end

        // R8 gated reset pulse length
        arm_expiry(32'h100, 32'h0, got);
        check("R8 expiry seen", got, 32'd1);
        n = 0;
        while (rst_out && n < 40) begin n++; @(negedge clk); end
        check("R8 pulse length", n, 32'd16);

        // R9 blocked by each condition
        arm_expiry(32'h0, 32'h0, got);
        seen = 0;
        for (int j = 0; j < 20; j++) begin if (rst_out) seen = 1; @(negedge clk); end
        check("R9 blocked by enable clear", seen, 32'd0);

        arm_expiry(32'h100, 32'h400, got);
        seen = 0;
        for (int j = 0; j < 20; j++) begin if (rst_out) seen = 1; @(negedge clk); end
        check("R9 blocked by mask", seen, 32'd0);

        arm_expiry(32'h100, 32'h0, got);
        check("R9 pulse starts", {31'b0, rst_out}, 32'd1);
        wr(1'b0, 8'h00, 32'h0);
        check("R9 dropped by watchdog disable", {31'b0, rst_out}, 32'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule